// File: doc/BRIEF.md
# Dual-Mode Common Scan Shifter

This block is the row-scan register of an 80-output common (row) driver for a passive-matrix LCD panel. A scan token enters from an end pin and moves one stage per line-clock falling edge. The direction of travel is selectable. In single mode the stages form one long chain with one input pin and one cascade output pin. In dual mode the register splits into two half-length sections, and each section has its own input. Two halves of a panel can then be scanned together.

Each stage drives one common output. Every cycle, the stage bit, the frame-alternation phase and the display-enable input together pick a 2-bit drive-level code for that output. This code selects the analog level outside this block. The two end pins are bidirectional. The block reports which end pin acts as an output with one output-enable per pin.

The line clock is sampled in the system clock domain, and its falling edge is detected there. The scan register updates on the system clock edge that first sees the line clock low.

Top module: `common_scan_driver`

## Requirements
- R1: A synchronous reset clears every stage to 0 and clears the falling-edge detector. After reset, with phase 0 and display enabled, every output shows code 1 (level V1), and both cascade outputs are 0.
- R2: The register shifts only on the system clock edge where the line clock was 1 in the previous sample and is 0 now. Holding the line clock steady, or raising it, leaves every stage unchanged.
- R3: In single mode with direction 0, output 1 takes the left input pin, and output k takes the old value of output k-1.
- R4: In single mode with direction 1, output 80 takes the right input pin, and output k takes the old value of output k+1.
- R5: In dual mode with direction 0, output 1 takes the left pin and output 41 takes the middle pin. Nothing moves from output 40 into output 41.
- R6: In dual mode with direction 1, output 80 takes the right pin and output 40 takes the middle pin. Nothing moves from output 41 into output 40.
- R7: With direction 0, the right cascade output equals stage 80 and the left cascade output is 0. With direction 1, the left cascade output equals stage 1 and the right cascade output is 0.
- R8: Direction 0 asserts only the right output-enable. Direction 1 asserts only the left output-enable.
- R9: Output k's code sits on level bits [2k-1:2k-2]. With display enabled, the codes are: phase 0 and bit 0 give 1 (V1); phase 0 and bit 1 give 3 (V5); phase 1 and bit 0 give 2 (V4); phase 1 and bit 1 give 0 (V0).
- R10: While the display-enable input is low, every output shows code 0 (V0), whatever the phase and stage bits.
- R11: In single mode the middle input pin has no effect on any stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| line_clk | input | 1 | Line clock; its falling edge shifts the register |
| dual_mode | input | 1 | 0 = one chain, 1 = two half-length sections |
| scan_dir | input | 1 | 0 = toward higher outputs, 1 = toward lower outputs |
| m_phase | input | 1 | Frame-alternation phase |
| disp_on | input | 1 | Display enable; low forces all outputs to V0 |
| pin_left_i | input | 1 | Left end pin, input side |
| pin_mid_i | input | 1 | Middle pin, second-section input in dual mode |
| pin_right_i | input | 1 | Right end pin, input side |
| pin_left_o | output | 1 | Left end pin, cascade output side |
| pin_right_o | output | 1 | Right end pin, cascade output side |
| pin_left_oe | output | 1 | Left pin acts as output |
| pin_right_oe | output | 1 | Right pin acts as output |
| level_o | output | 160 | Two-bit drive code per output, output 1 in the low bits |

## Verification
A shift appears at the outputs on the first system clock edge that sees the line clock low. That is one register after the falling edge. The level codes, cascade outputs and output-enables follow the phase, display-enable and direction inputs with no register in between.

The bench changes inputs just after a falling system clock edge. Each line pulse spans two system edges. The bench reads stage contents at the next falling edge, after the shifting edge has passed. It checks combinational results one time unit after it drives them.

// File: rtl/comscan_pkg.sv
package comscan_pkg;
    typedef enum logic [1:0] {
        LVL_V0 = 2'd0,
        LVL_V1 = 2'd1,
        LVL_V4 = 2'd2,
        LVL_V5 = 2'd3
    } drive_lvl_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } scan_dir_e;
endpackage

// File: rtl/line_edge_detect.sv
module line_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic line_clk,
    output logic fall_o
);
    typedef struct packed {
        logic line;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d      = det_q;
        det_d.line = line_clk;
        if (rst) det_d.line = 1'b0;
    end

    always_ff @(posedge clk) begin
        det_q <= det_d;
    end

    assign fall_o = det_q.line & ~line_clk & ~rst;
endmodule

// File: rtl/scan_register.sv
module scan_register #(
    parameter int NUM_OUT = 80
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               shift_en,
    input  logic               dual_mode,
    input  logic               scan_dir,
    input  logic               in_left,
    input  logic               in_mid,
    input  logic               in_right,
    output logic [NUM_OUT-1:0] stage_o
);
    import comscan_pkg::*;

    localparam int HALF = NUM_OUT / 2;

    typedef struct packed {
        logic [NUM_OUT-1:0] stage;
    } reg_t;

    reg_t reg_d, reg_q;
    logic [NUM_OUT-1:0] up_src;
    logic [NUM_OUT-1:0] down_src;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_src
        if (i == 0) begin : g_up_head
            assign up_src[i] = in_left;
        end else if (i == HALF) begin : g_up_split
            assign up_src[i] = dual_mode ? in_mid : reg_q.stage[i-1];
        end else begin : g_up_body
            assign up_src[i] = reg_q.stage[i-1];
        end

        if (i == NUM_OUT - 1) begin : g_dn_head
            assign down_src[i] = in_right;
        end else if (i == HALF - 1) begin : g_dn_split
            assign down_src[i] = dual_mode ? in_mid : reg_q.stage[i+1];
        end else begin : g_dn_body
            assign down_src[i] = reg_q.stage[i+1];
        end
    end

    always_comb begin
        reg_d = reg_q;
        if (shift_en) begin
            reg_d.stage = (scan_dir_e'(scan_dir) == DIR_DOWN) ? down_src : up_src;
        end
        if (rst) reg_d.stage = '0;
    end

    always_ff @(posedge clk) begin
        reg_q <= reg_d;
    end

    assign stage_o = reg_q.stage;
endmodule

// File: rtl/level_encoder.sv
module level_encoder #(
    parameter int NUM_OUT = 80
) (
    input  logic [NUM_OUT-1:0]   stage_i,
    input  logic                 m_phase,
    input  logic                 disp_on,
    output logic [2*NUM_OUT-1:0] level_o
);
    import comscan_pkg::*;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_lvl
        drive_lvl_e code;
        always_comb begin
            if (!disp_on) begin
                code = LVL_V0;
            end else begin
                case ({m_phase, stage_i[i]})
                    2'b00:   code = LVL_V1;
                    2'b01:   code = LVL_V5;
                    2'b10:   code = LVL_V4;
                    default: code = LVL_V0;
                endcase
            end
        end
        assign level_o[2*i +: 2] = code;
    end
endmodule

// File: rtl/common_scan_driver.sv
module common_scan_driver #(
    parameter int NUM_OUT = 80
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 line_clk,
    input  logic                 dual_mode,
    input  logic                 scan_dir,
    input  logic                 m_phase,
    input  logic                 disp_on,
    input  logic                 pin_left_i,
    input  logic                 pin_mid_i,
    input  logic                 pin_right_i,
    output logic                 pin_left_o,
    output logic                 pin_right_o,
    output logic                 pin_left_oe,
    output logic                 pin_right_oe,
    output logic [2*NUM_OUT-1:0] level_o
);
    import comscan_pkg::*;

    logic               shift_en;
    logic [NUM_OUT-1:0] stages;
    logic               going_down;

    line_edge_detect u_edge (
        .clk     (clk),
        .rst     (rst),
        .line_clk(line_clk),
        .fall_o  (shift_en)
    );

    scan_register #(.NUM_OUT(NUM_OUT)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .dual_mode(dual_mode),
        .scan_dir (scan_dir),
        .in_left  (pin_left_i),
        .in_mid   (pin_mid_i),
        .in_right (pin_right_i),
        .stage_o  (stages)
    );

    level_encoder #(.NUM_OUT(NUM_OUT)) u_lvl (
        .stage_i(stages),
        .m_phase(m_phase),
        .disp_on(disp_on),
        .level_o(level_o)
    );

    assign going_down   = (scan_dir_e'(scan_dir) == DIR_DOWN);
    assign pin_left_oe  = going_down;
    assign pin_right_oe = ~going_down;
    assign pin_left_o   = going_down  ? stages[0]         : 1'b0;
    assign pin_right_o  = !going_down ? stages[NUM_OUT-1] : 1'b0;
endmodule

// File: rtl/common_scan_checker.sv
module common_scan_checker #(
    parameter int NUM_OUT = 80
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 line_clk,
    input logic                 dual_mode,
    input logic                 scan_dir,
    input logic                 m_phase,
    input logic                 disp_on,
    input logic                 pin_left_i,
    input logic                 pin_mid_i,
    input logic                 pin_right_i,
    input logic                 pin_left_o,
    input logic                 pin_right_o,
    input logic                 pin_left_oe,
    input logic                 pin_right_oe,
    input logic [2*NUM_OUT-1:0] level_o
);
    localparam int HALF = NUM_OUT / 2;

    logic               seen_q;
    logic               fell;
    logic [NUM_OUT-1:0] bits_obs;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= line_clk;
    end
    assign fell = seen_q & ~line_clk;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_obs
        assign bits_obs[i] = m_phase ? (level_o[2*i +: 2] == 2'd0)
                                     : (level_o[2*i +: 2] == 2'd3);
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!fell && disp_on && !line_clk && !$isunknown(bits_obs)) |=> (!disp_on || $stable(bits_obs)))
        else $error("stages moved without a line clock fall");

    assert_single_up_R3: assert property (@(posedge clk) disable iff (rst)
        (fell && !dual_mode && !scan_dir) |=> (!disp_on || bits_obs[0] == $past(pin_left_i)))
        else $error("output 1 did not take the left pin");

    assert_single_down_R4: assert property (@(posedge clk) disable iff (rst)
        (fell && !dual_mode && scan_dir) |=> (!disp_on || bits_obs[NUM_OUT-1] == $past(pin_right_i)))
        else $error("last output did not take the right pin");

    assert_dual_mid_R5: assert property (@(posedge clk) disable iff (rst)
        (fell && dual_mode && !scan_dir) |=> (!disp_on || bits_obs[HALF] == $past(pin_mid_i)))
        else $error("upper section head did not take the middle pin");

    assert_cascade_R7: assert property (@(posedge clk) disable iff (rst)
        disp_on |-> (scan_dir ? (pin_left_o == bits_obs[0] && !pin_right_o)
                              : (pin_right_o == bits_obs[NUM_OUT-1] && !pin_left_o)))
        else $error("cascade output does not match end stage");

    assert_oe_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot({pin_left_oe, pin_right_oe}) && (pin_left_oe == scan_dir))
        else $error("output enables wrong");

    assert_dispoff_R10: assert property (@(posedge clk) disable iff (rst)
        !disp_on |-> (level_o == '0))
        else $error("display off did not force V0");
endmodule

bind common_scan_driver common_scan_checker #(.NUM_OUT(NUM_OUT)) u_chk (.*);

// File: tb/tb_common_scan_driver.sv
module tb_common_scan_driver;
    localparam int CLK_PERIOD = 10;
    localparam int N = 80;
    localparam int H = N / 2;

    logic clk = 1'b0;
    logic rst, line_clk, dual_mode, scan_dir, m_phase, disp_on;
    logic pin_left_i, pin_mid_i, pin_right_i;
    logic pin_left_o, pin_right_o, pin_left_oe, pin_right_oe;
    logic [2*N-1:0] level_o;

    int checks = 0;
    int errors = 0;

    common_scan_driver #(.NUM_OUT(N)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // {stage bit, phase, display enable, expected code of output 1}
    localparam logic [4:0] VEC [6] = '{
        {1'b0, 1'b0, 1'b1, 2'd1},
        {1'b1, 1'b0, 1'b1, 2'd3},
        {1'b0, 1'b1, 1'b1, 2'd2},
        {1'b1, 1'b1, 1'b1, 2'd0},
        {1'b0, 1'b0, 1'b0, 2'd0},
        {1'b1, 1'b1, 1'b0, 2'd0}
    };

    function automatic logic [N-1:0] bits_now();
        logic [N-1:0] b;
        for (int i = 0; i < N; i++) b[i] = (level_o[2*i +: 2] == 2'd3);
        return b;
    endfunction

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; line_clk = 1'b0; m_phase = 1'b0; disp_on = 1'b1;
        pin_left_i = 1'b0; pin_mid_i = 1'b0; pin_right_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic line_pulse();
        line_clk = 1'b1;
        @(negedge clk);
        line_clk = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int k = 0; k < n; k++) line_pulse();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [N-1:0] exp;
        rst = 1'b1; line_clk = 1'b0; dual_mode = 1'b0; scan_dir = 1'b0;
        m_phase = 1'b0; disp_on = 1'b1;
        pin_left_i = 1'b0; pin_mid_i = 1'b0; pin_right_i = 1'b0;

        // R9 / R10 table walk on output 1
        for (int v = 0; v < 6; v++) begin
            do_reset();
            dual_mode = 1'b0; scan_dir = 1'b0;
            if (VEC[v][4]) begin
                pin_left_i = 1'b1;
                line_pulse();
                pin_left_i = 1'b0;
            end
            m_phase = VEC[v][3];
            disp_on = VEC[v][2];
            #1;
            chk(VEC[v][2] ? "R9 code" : "R10 code", N'(level_o[1:0]), N'(VEC[v][1:0]));
        end

        // R1 reset state
        do_reset();
        exp = '0;
        for (int i = 0; i < N; i++) exp[i] = (level_o[2*i +: 2] == 2'd1);
        chk("R1 all V1", exp, {N{1'b1}});
        chk("R1 cascade", N'({pin_left_o, pin_right_o}), '0);

        // R3 / R7 / R8 / R11 single up, middle pin held high
        dual_mode = 1'b0; scan_dir = 1'b0; pin_mid_i = 1'b1;
        #1;
        chk("R8 oe up", N'({pin_left_oe, pin_right_oe}), N'(2'b01));
        pin_left_i = 1'b1;
        line_pulse();
        pin_left_i = 1'b0;
        exp = '0; exp[0] = 1'b1;
        chk("R3 first", bits_now(), exp);
        chk("R11 mid ignored", bits_now(), exp);
        chk("R7 left out zero", N'(pin_left_o), '0);
        // R2: hold high and low, rising edge alone
        line_clk = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 hold high", bits_now(), exp);
        line_clk = 1'b0;
        repeat (2) @(negedge clk);
        exp = '0; exp[1] = 1'b1;
        chk("R2 fall shifts", bits_now(), exp);
        repeat (4) @(negedge clk);
        chk("R2 hold low", bits_now(), exp);
        pulses(N - 3);
        exp = '0; exp[N-2] = 1'b1;
        chk("R3 travel", bits_now(), exp);
        line_pulse();
        chk("R7 right out", N'(pin_right_o), N'(1'b1));
        line_pulse();
        chk("R3 leaves", bits_now(), '0);
        pin_mid_i = 1'b0;

        // R4 / R7 / R8 single down
        do_reset();
        dual_mode = 1'b0; scan_dir = 1'b1;
        #1;
        chk("R8 oe down", N'({pin_left_oe, pin_right_oe}), N'(2'b10));
        pin_right_i = 1'b1;
        line_pulse();
        pin_right_i = 1'b0;
        exp = '0; exp[N-1] = 1'b1;
        chk("R4 first", bits_now(), exp);
        chk("R7 right out zero", N'(pin_right_o), '0);
        pulses(N - 1);
        exp = '0; exp[0] = 1'b1;
        chk("R4 travel", bits_now(), exp);
        chk("R7 left out", N'(pin_left_o), N'(1'b1));

        // R5 dual up
        do_reset();
        dual_mode = 1'b1; scan_dir = 1'b0;
        pin_left_i = 1'b1; pin_mid_i = 1'b1;
        line_pulse();
        pin_left_i = 1'b0; pin_mid_i = 1'b0;
        exp = '0; exp[0] = 1'b1; exp[H] = 1'b1;
        chk("R5 heads", bits_now(), exp);
        pulses(H - 1);
        exp = '0; exp[H-1] = 1'b1; exp[N-1] = 1'b1;
        chk("R5 tails", bits_now(), exp);
        chk("R7 dual cascade", N'(pin_right_o), N'(1'b1));
        line_pulse();
        chk("R5 no crossing", bits_now(), '0);

        // R6 dual down
        do_reset();
        dual_mode = 1'b1; scan_dir = 1'b1;
        pin_right_i = 1'b1; pin_mid_i = 1'b1;
        line_pulse();
        pin_right_i = 1'b0; pin_mid_i = 1'b0;
        exp = '0; exp[N-1] = 1'b1; exp[H-1] = 1'b1;
        chk("R6 heads", bits_now(), exp);
        pulses(H - 1);
        exp = '0; exp[H] = 1'b1; exp[0] = 1'b1;
        chk("R6 tails", bits_now(), exp);
        line_pulse();
        chk("R6 no crossing", bits_now(), '0);

        // R10 whole row forced off, and R1 reset mid-run
        do_reset();
        dual_mode = 1'b0; scan_dir = 1'b0; pin_left_i = 1'b1;
        pulses(5);
        pin_left_i = 1'b0;
        disp_on = 1'b0; m_phase = 1'b1;
        #1;
        chk("R10 all V0", level_o[N-1:0], '0);
        chk("R10 all V0 high", level_o[2*N-1:N], '0);
        disp_on = 1'b1; m_phase = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 mid-run clear", bits_now(), '0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule